// File: doc/BRIEF.md
# Multiplexed Character Display Refresh Controller

The block keeps a small character store of up to sixteen bytes and refreshes a multiplexed display from it. One scan counter visits the digit positions in turn. For the current position it drives the index and the byte, given as a high nibble and a low nibble. Each position is held for a fixed number of prescaled ticks. The display is blanked at the start of every position, so a stale character does not ghost onto the next digit.

A host writes to the block over a byte-wide write port, with one select line that picks the control port or the data port. The three most significant bits of a control byte give its type. These types set the digit count and the entry direction, load the write address and the auto-increment flag, set the per-nibble write inhibit and blanking, and clear the store. In left entry, data goes to the addressed position. In right entry, each new character enters at the last position and pushes the others one place toward position 0.

Top module: `disp_scan_ctrl`

## Requirements
- R1: After reset, scan_o is 0, blank_o is 1, both nibble outputs are 0, every stored byte is 0x00, the mode is 00 and the write address is 0 with auto-increment off.
- R2: A control byte is decoded by bits [7:5]: 000 mode, 100 address, 101 inhibit/blank, 110 clear. The codes 001, 010, 011 and 111 change nothing.
- R3: A mode word takes bits [1:0]: 00 is 8 digits left entry, 01 is 16 digits left entry, 10 is 8 digits right entry, 11 is 16 digits right entry. The edge that stores it restarts the scan at position 0, blanked.
- R4: Each position is held for PRESC_DIV*DWELL clock cycles. The scan then steps by one and wraps after position 7 or position 15, according to the mode.
- R5: blank_o is high for the first PRESC_DIV cycles of every position, and both nibble outputs read 0 while it is high.
- R6: An address word loads the write address from bits [3:0] and the auto-increment flag from bit 4. In left entry, a data byte is stored at the address; with auto-increment set, the address then steps and wraps at the digit count.
- R7: With auto-increment clear, the address stays fixed, so repeated data bytes overwrite the same position.
- R8: In right entry, a data byte shifts positions 1..N-1 down by one position and is stored at position N-1. The address is not used.
- R9: An inhibit/blank word bit 3 keeps the stored high nibble on a left-entry write, and bit 2 keeps the low nibble. In right entry, an inhibited half of the entering byte is stored as 0.
- R10: Inhibit/blank word bit 1 forces nib_hi_o to 0 and bit 0 forces nib_lo_o to 0. The stored bytes are not changed.
- R11: A clear word sets every stored byte to 0x00 and the write address to 0.
- R12: Outside blanking, nib_hi_o is bits [7:4] and nib_lo_o is bits [3:0] of the byte stored at position scan_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe, one byte per cycle |
| ctrl_sel_i | input | 1 | 1 selects the control port, 0 the data port |
| wdata_i | input | 8 | Write byte |
| scan_o | output | 4 | Index of the digit being refreshed |
| nib_hi_o | output | 4 | High half of the refreshed character |
| nib_lo_o | output | 4 | Low half of the refreshed character |
| blank_o | output | 1 | Blanking during the digit transition |

## Verification
Host writes to the store and the scan read of the same position can fall in the same cycle. So can a mode or clear word and a digit step of the scan counter. The bench issues writes at arbitrary points of a running frame, including while the written position is on display. It then compares the whole next frame, position by position, against a model built from the requirements. The bench also writes mode words in mid-scan and checks that the step boundary gives way to the restart: position 0 and blanking on the following edge, and after that a full dwell time per position.

// File: rtl/disp_pkg.sv
package disp_pkg;
  localparam logic [2:0] CW_MODE = 3'b000;
  localparam logic [2:0] CW_ADDR = 3'b100;
  localparam logic [2:0] CW_MASK = 3'b101;
  localparam logic [2:0] CW_CLR  = 3'b110;

  typedef struct packed {
    logic right;  // right entry
    logic wide;   // 16 digits
  } mode_t;

  typedef struct packed {
    logic inh_hi;
    logic inh_lo;
    logic blk_hi;
    logic blk_lo;
  } mask_t;
endpackage

// File: rtl/disp_cmd_dec.sv
module disp_cmd_dec
  import disp_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic       ctrl_sel_i,
  input  logic [7:0] wdata_i,
  output mode_t      mode_o,
  output mask_t      mask_o,
  output logic       mode_wr_o,
  output logic       addr_wr_o,
  output logic       clr_o,
  output logic       data_wr_o
);
  logic       cw;
  logic       mask_wr;
  logic [2:0] kind;

  always_comb begin
    kind      = wdata_i[7:5];
    cw        = wr_en_i & ctrl_sel_i;
    mode_wr_o = cw && (kind == CW_MODE);
    addr_wr_o = cw && (kind == CW_ADDR);
    mask_wr   = cw && (kind == CW_MASK);
    clr_o     = cw && (kind == CW_CLR);
    data_wr_o = wr_en_i & ~ctrl_sel_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o <= '0;
      mask_o <= '0;
    end else begin
      if (mode_wr_o) mode_o <= mode_t'(wdata_i[1:0]);
      if (mask_wr)   mask_o <= mask_t'(wdata_i[3:0]);
    end
  end
endmodule

// File: rtl/disp_ram.sv
module disp_ram
  import disp_pkg::*;
#(
  parameter int MAX_DIGITS = 16,
  parameter int AW         = $clog2(MAX_DIGITS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  mode_t         mode_i,
  input  logic          inh_hi_i,
  input  logic          inh_lo_i,
  input  logic          addr_wr_i,
  input  logic          clr_i,
  input  logic          data_wr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [7:0]    rd_data_o
);
  localparam logic [AW-1:0] LAST_WIDE   = AW'(MAX_DIGITS - 1);
  localparam logic [AW-1:0] LAST_NARROW = AW'(MAX_DIGITS / 2 - 1);

  logic [7:0]    ram_q [MAX_DIGITS];
  logic [AW-1:0] addr_q, last, eff;
  logic          ainc_q;
  logic [7:0]    lnew, rnew;

  always_comb begin
    last = mode_i.wide ? LAST_WIDE : LAST_NARROW;
    eff  = addr_q & last;  // digit counts are powers of two
    lnew = {inh_hi_i ? ram_q[eff][7:4] : wdata_i[7:4],
            inh_lo_i ? ram_q[eff][3:0] : wdata_i[3:0]};
    rnew = {inh_hi_i ? 4'h0 : wdata_i[7:4],
            inh_lo_i ? 4'h0 : wdata_i[3:0]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < MAX_DIGITS; i++) ram_q[i] <= '0;
      addr_q <= '0;
      ainc_q <= 1'b0;
    end else if (clr_i) begin
      for (int i = 0; i < MAX_DIGITS; i++) ram_q[i] <= '0;
      addr_q <= '0;
    end else if (addr_wr_i) begin
      addr_q <= wdata_i[AW-1:0];
      ainc_q <= wdata_i[4];
    end else if (data_wr_i) begin
      if (mode_i.right) begin
        for (int i = 0; i < MAX_DIGITS - 1; i++)
          if (AW'(i) < last) ram_q[i] <= ram_q[i+1];
        ram_q[last] <= rnew;
      end else begin
        ram_q[eff] <= lnew;
        if (ainc_q) addr_q <= (eff == last) ? '0 : eff + 1'b1;
      end
    end
  end

  assign rd_data_o = ram_q[rd_addr_i];
endmodule

// File: rtl/disp_scan_timer.sv
module disp_scan_timer #(
  parameter int MAX_DIGITS = 16,
  parameter int PRESC_DIV  = 4,
  parameter int DWELL      = 4,
  parameter int AW         = $clog2(MAX_DIGITS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          restart_i,
  input  logic          wide_i,
  output logic [AW-1:0] scan_o,
  output logic          blank_o
);
  localparam int PW = $clog2(PRESC_DIV + 1);
  localparam int DW = $clog2(DWELL + 1);
  localparam logic [PW-1:0] PRE_TOP   = PW'(PRESC_DIV - 1);
  localparam logic [DW-1:0] DWELL_TOP = DW'(DWELL - 1);
  localparam logic [AW-1:0] LAST_WIDE   = AW'(MAX_DIGITS - 1);
  localparam logic [AW-1:0] LAST_NARROW = AW'(MAX_DIGITS / 2 - 1);

  logic [PW-1:0] pre_q;
  logic [DW-1:0] dwell_q;
  logic [AW-1:0] scan_q, last;
  logic          tick, step;

  always_comb begin
    tick = (pre_q == PRE_TOP);
    step = tick && (dwell_q == DWELL_TOP);
    last = wide_i ? LAST_WIDE : LAST_NARROW;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q   <= '0;
      dwell_q <= '0;
      scan_q  <= '0;
    end else if (restart_i) begin
      pre_q   <= '0;
      dwell_q <= '0;
      scan_q  <= '0;
    end else begin
      pre_q <= tick ? '0 : pre_q + 1'b1;
      if (step) begin
        dwell_q <= '0;
        scan_q  <= (scan_q >= last) ? '0 : scan_q + 1'b1;
      end else if (tick) begin
        dwell_q <= dwell_q + 1'b1;
      end
    end
  end

  assign scan_o  = scan_q;
  assign blank_o = (dwell_q == '0);
endmodule

// File: rtl/disp_scan_ctrl.sv
module disp_scan_ctrl
  import disp_pkg::*;
#(
  parameter int MAX_DIGITS = 16,
  parameter int PRESC_DIV  = 4,
  parameter int DWELL      = 4,
  localparam int AW        = $clog2(MAX_DIGITS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          ctrl_sel_i,
  input  logic [7:0]    wdata_i,
  output logic [AW-1:0] scan_o,
  output logic [3:0]    nib_hi_o,
  output logic [3:0]    nib_lo_o,
  output logic          blank_o
);
  mode_t      mode_q;
  mask_t      mask_q;
  logic       mode_wr, addr_wr, clr, data_wr;
  logic [7:0] cur_byte;

  disp_cmd_dec u_dec (
    .clk_i, .rst_ni, .wr_en_i, .ctrl_sel_i, .wdata_i,
    .mode_o(mode_q), .mask_o(mask_q),
    .mode_wr_o(mode_wr), .addr_wr_o(addr_wr), .clr_o(clr), .data_wr_o(data_wr)
  );

  disp_ram #(.MAX_DIGITS(MAX_DIGITS), .AW(AW)) u_ram (
    .clk_i, .rst_ni,
    .mode_i(mode_q), .inh_hi_i(mask_q.inh_hi), .inh_lo_i(mask_q.inh_lo),
    .addr_wr_i(addr_wr), .clr_i(clr), .data_wr_i(data_wr), .wdata_i,
    .rd_addr_i(scan_o), .rd_data_o(cur_byte)
  );

  disp_scan_timer #(.MAX_DIGITS(MAX_DIGITS), .PRESC_DIV(PRESC_DIV),
                    .DWELL(DWELL), .AW(AW)) u_scan (
    .clk_i, .rst_ni, .restart_i(mode_wr), .wide_i(mode_q.wide),
    .scan_o, .blank_o
  );

  assign nib_hi_o = (blank_o || mask_q.blk_hi) ? 4'h0 : cur_byte[7:4];
  assign nib_lo_o = (blank_o || mask_q.blk_lo) ? 4'h0 : cur_byte[3:0];
endmodule

// File: rtl/disp_scan_ctrl_chk.sv
module disp_scan_ctrl_chk #(
  parameter int MAX_DIGITS = 16,
  localparam int AW        = $clog2(MAX_DIGITS)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [AW-1:0] scan_o,
  input logic          blank_o,
  input logic [3:0]    nib_hi_o,
  input logic [3:0]    nib_lo_o,
  input logic          wide_i,
  input logic          restart_i,
  input logic          clr_i
);
  localparam int HALF = MAX_DIGITS / 2;

  // R4
  scan_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wide_i |-> (int'(scan_o) < HALF));

  // R4
  scan_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((scan_o != $past(scan_o)) && !$past(restart_i)) |->
      ((scan_o == $past(scan_o) + 1'b1) || (scan_o == '0)));

  // R5
  step_blank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scan_o != $past(scan_o)) |-> blank_o);

  // R5
  blank_dark_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blank_o |-> (nib_hi_o == 4'h0 && nib_lo_o == 4'h0));

  // R3
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (scan_o == '0 && blank_o));

  // R11
  clear_dark_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (nib_hi_o == 4'h0 && nib_lo_o == 4'h0));
endmodule

bind disp_scan_ctrl disp_scan_ctrl_chk #(.MAX_DIGITS(MAX_DIGITS)) u_chk (
  .clk_i, .rst_ni, .scan_o, .blank_o, .nib_hi_o, .nib_lo_o,
  .wide_i(mode_q.wide), .restart_i(mode_wr), .clr_i(clr)
);

// File: tb/sim_disp_scan_ctrl.sv
`timescale 1ns/1ps
module sim_disp_scan_ctrl;
  localparam int PRE = 4;
  localparam int DWL = 4;

  typedef struct {
    int       pos;
    logic [3:0] hi;
    logic [3:0] lo;
  } item_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, sel = 1'b0;
  logic [7:0] wd = '0;
  logic [3:0] scan_o, nib_hi, nib_lo;
  logic       blank_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  item_t exp_q[$];

  // model state
  logic [7:0] mdl [16];
  bit m_wide, m_right, m_ainc, inh_hi, inh_lo, blk_hi, blk_lo;
  int m_addr;

  always #2.5 clk = ~clk;

  disp_scan_ctrl #(.MAX_DIGITS(16), .PRESC_DIV(PRE), .DWELL(DWL)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .ctrl_sel_i(sel),
    .wdata_i(wd), .scan_o(scan_o), .nib_hi_o(nib_hi), .nib_lo_o(nib_lo),
    .blank_o(blank_o)
  );

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: compare on first unblanked cycle of each position
  logic prev_blank = 1'b1;
  always @(negedge clk) begin
    if (rst_n && prev_blank && !blank_o && exp_q.size() > 0) begin
      item_t it;
      it = exp_q.pop_front();
      check(scan_o == it.pos[3:0], "R4 scan order", scan_o, it.pos);
      check(nib_hi == it.hi, "R12 high nibble", nib_hi, it.hi);
      check(nib_lo == it.lo, "R12 low nibble", nib_lo, it.lo);
    end
    prev_blank = blank_o;
  end

  task automatic bus(bit s, logic [7:0] b);
    @(negedge clk);
    wr_en = 1'b1; sel = s; wd = b;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ctrl(logic [7:0] b);
    bus(1'b1, b);
    case (b[7:5])
      3'b000: begin m_wide = b[0]; m_right = b[1]; end
      3'b100: begin m_addr = b[3:0]; m_ainc = b[4]; end
      3'b101: begin inh_hi = b[3]; inh_lo = b[2]; blk_hi = b[1]; blk_lo = b[0]; end
      3'b110: begin for (int i = 0; i < 16; i++) mdl[i] = 8'h00; m_addr = 0; end
      default: ;
    endcase
  endtask

  task automatic dat(logic [7:0] b);
    int last;
    bus(1'b0, b);
    last = m_wide ? 15 : 7;
    if (m_right) begin
      for (int i = 0; i < last; i++) mdl[i] = mdl[i+1];
      mdl[last] = {inh_hi ? 4'h0 : b[7:4], inh_lo ? 4'h0 : b[3:0]};
    end else begin
      int ea;
      ea = m_addr & last;
      mdl[ea] = {inh_hi ? mdl[ea][7:4] : b[7:4], inh_lo ? mdl[ea][3:0] : b[3:0]};
      if (m_ainc) m_addr = (ea == last) ? 0 : ea + 1;
    end
  endtask

  // driver: queue one full frame of expected items
  task automatic frame();
    int n;
    n = m_wide ? 16 : 8;
    @(negedge clk);
    while (!(scan_o == 4'd0 && blank_o)) @(negedge clk);
    for (int p = 0; p < n; p++) begin
      item_t it;
      it.pos = p;
      it.hi  = blk_hi ? 4'h0 : mdl[p][7:4];
      it.lo  = blk_lo ? 4'h0 : mdl[p][3:0];
      exp_q.push_back(it);
    end
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) mdl[i] = 8'h00;
    m_wide = 0; m_right = 0; m_ainc = 0; m_addr = 0;
    inh_hi = 0; inh_lo = 0; blk_hi = 0; blk_lo = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(scan_o == 0, "R1 scan", scan_o, 0);
    check(blank_o == 1'b1, "R1 blank", blank_o, 1);
    check(nib_hi == 0 && nib_lo == 0, "R1 nibbles", {nib_hi, nib_lo}, 0);
    frame();  // R1 store empty, mode 00

    // R6 left entry with auto-increment and wrap
    ctrl(8'h90);
    dat(8'h12); dat(8'h34); dat(8'h56);
    frame();
    dat(8'h9A); dat(8'hBC); dat(8'hDE); dat(8'hF1); dat(8'h23);
    dat(8'hAB);  // wraps to position 0
    frame();

    // R7 fixed address overwrite
    ctrl(8'h85);
    dat(8'h77); dat(8'h88);
    frame();

    // R9 nibble write inhibit in left entry
    ctrl(8'hA8); ctrl(8'h82); dat(8'hFF);
    ctrl(8'hA4); dat(8'h00);
    ctrl(8'hA0);
    frame();

    // R10 blanking, store kept
    ctrl(8'hA2); frame();
    ctrl(8'hA1); frame();
    ctrl(8'hA0); frame();

    // R2 unused control codes change nothing
    ctrl(8'h3F); ctrl(8'h5F); ctrl(8'h7F); ctrl(8'hFF);
    dat(8'h4C);  // address and auto-increment unchanged
    frame();

    // R4 wrap after position 7 in 8-digit mode
    while (scan_o != 4'd7) @(negedge clk);
    while (scan_o == 4'd7) @(negedge clk);
    check(scan_o == 0, "R4 wrap at 8", scan_o, 0);

    // R3 16-digit left entry; restart on mode write
    ctrl(8'h01);
    check(scan_o == 0 && blank_o, "R3 restart", {scan_o, blank_o}, 1);
    frame();

    // R4 dwell length and R5 blank length
    begin
      int cyc, blk;
      logic [3:0] s0;
      s0 = scan_o;
      while (scan_o == s0) @(negedge clk);
      s0 = scan_o; cyc = 0; blk = 0;
      while (scan_o == s0) begin
        if (blank_o) blk++;
        cyc++;
        @(negedge clk);
      end
      check(cyc == PRE * DWL, "R4 dwell cycles", cyc, PRE * DWL);
      check(blk == PRE, "R5 blank cycles", blk, PRE);
    end
    while (scan_o != 4'd15) @(negedge clk);
    while (scan_o == 4'd15) @(negedge clk);
    check(scan_o == 0, "R4 wrap at 16", scan_o, 0);

    // R11 clear resets store and address
    ctrl(8'hC0);
    frame();
    dat(8'h5A);
    frame();

    // R8 right entry, 8 digits
    ctrl(8'h02); ctrl(8'hC0);
    dat(8'h11); dat(8'h22); dat(8'h33);
    frame();
    ctrl(8'hA8); dat(8'h44); ctrl(8'hA0);  // R9 right-entry inhibit
    frame();

    // R8 right entry, 16 digits
    ctrl(8'h03);
    dat(8'h99); dat(8'h66);
    frame();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule